// File: doc/BRIEF.md
# 16-bit Multicycle Instruction Sequencer

This block is the control unit and small datapath of a word-addressed 16-bit load/store machine. It holds a program counter, an instruction register, memory address and memory data registers, and eight 16-bit general registers. It reaches one single-port memory through an address bus, a write-data bus, a read-data bus and separate read and write strobes. The memory answers one clock after a strobe.

Every instruction moves through a fixed chain of phases. Fetch takes three cycles: load the address register, read, then capture. After fetch come decode, address evaluation, operand fetch, execute and store-result. A recognised instruction always takes eight cycles. The supported instructions are add and bitwise AND, each with a register or an immediate second operand, a base-plus-offset load, a base-plus-offset store, a jump through a register, and halt. Halt stops the machine until reset. A debug port shows the current phase, the PC and the IR, so that a bench or an integrating block can follow progress.

Top module: `seq16_core`

## Requirements
- R1: While the synchronous reset `rst` is high, the PC is cleared to 0, the phase returns to fetch (code 0), `halted` is low, both strobes are low and all eight general registers are cleared to zero.
- R2: In the cycle after the fetch phase, `mem_rd` is high and `mem_addr` carries the old PC, and the PC has already advanced by one. The fetched word shows on `dbg_ir` from the decode phase onward.
- R3: Opcode bits[15:12]=0001 with bit 5 clear adds register bits[8:6] and register bits[2:0] and writes the sum to register bits[11:9], with 16-bit wrap-around.
- R4: For opcodes 0001 and 0101 with bit 5 set, bits[4:0] are a two's-complement value. It is sign-extended to 16 bits and used as the second operand.
- R5: Opcode 0101 has the same field layout as add and writes the bitwise AND of its operands.
- R6: Opcode 0110 forms the address as register bits[8:6] plus the sign-extended 6-bit field bits[5:0]. It reads that memory word and writes it to register bits[11:9].
- R7: Opcode 0111 forms its address the same way and writes register bits[11:9] to it. `mem_wr` rises only in the store-result phase and only for this opcode.
- R8: Opcode 1100 loads the PC with register bits[8:6] and changes no register and no memory word.
- R9: Phase codes run 0 fetch, 1 read, 2 capture, 3 decode, 4 address, 5 operands, 6 execute, 7 store, and each phase lasts one cycle. After the store phase comes fetch, so a recognised instruction takes eight cycles.
- R10: Opcode 1111 enters the halt phase (code 8) four cycles after its fetch began and raises `halted`. The phase, the PC and both strobes stay frozen until reset.
- R11: Any other opcode is a no-op: after decode the phase goes straight back to fetch (four cycles in all), and no register or memory word changes.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address, taken from the address register |
| mem_wdata | output | 16 | Memory write data, taken from the data register |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| halted | output | 1 | High once a halt instruction has been decoded |
| dbg_phase | output | 4 | Current phase code |
| dbg_pc | output | 16 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |

## Verification
The general registers have no port of their own. Their contents, including the cleared state after reset and the unchanged state after an unrecognised opcode, become visible only when a program stores them to memory. Each scenario therefore loads a short program that ends in halt and then reads the memory image back. Values too wide for a 5-bit immediate are planted as data words and brought in with loads. The load and store paths with negative offsets get their own test, in which a base register is first built up by repeated additions.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

   typedef enum logic [3:0] {
      PH_FETCH  = 4'd0,
      PH_FREAD  = 4'd1,
      PH_FLOAD  = 4'd2,
      PH_DECODE = 4'd3,
      PH_EVAL   = 4'd4,
      PH_OPS    = 4'd5,
      PH_EXEC   = 4'd6,
      PH_STORE  = 4'd7,
      PH_HALT   = 4'd8
   } phase_t;

   localparam logic [3:0] OPC_ADD  = 4'b0001;
   localparam logic [3:0] OPC_AND  = 4'b0101;
   localparam logic [3:0] OPC_LOAD = 4'b0110;
   localparam logic [3:0] OPC_STOR = 4'b0111;
   localparam logic [3:0] OPC_JUMP = 4'b1100;
   localparam logic [3:0] OPC_STOP = 4'b1111;

endpackage

// File: rtl/seq16_decode.sv
module seq16_decode
   import seq16_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] ir,
   output logic [2:0]        f_dst,
   output logic [2:0]        f_src1,
   output logic [2:0]        f_src2,
   output logic              imm_mode,
   output logic [WORD_W-1:0] imm_val,
   output logic [WORD_W-1:0] off_val,
   output logic              is_alu,
   output logic              is_and,
   output logic              is_ld,
   output logic              is_st,
   output logic              is_jmp,
   output logic              is_halt
);
   logic [3:0] opc;

   always_comb begin
      opc      = ir[15:12];
      f_dst    = ir[11:9];
      f_src1   = ir[8:6];
      f_src2   = ir[2:0];
      imm_mode = ir[5];
      imm_val  = {{(WORD_W-5){ir[4]}}, ir[4:0]};
      off_val  = {{(WORD_W-6){ir[5]}}, ir[5:0]};
      is_and   = (opc == OPC_AND);
      is_alu   = (opc == OPC_ADD) || is_and;
      is_ld    = (opc == OPC_LOAD);
      is_st    = (opc == OPC_STOR);
      is_jmp   = (opc == OPC_JUMP);
      is_halt  = (opc == OPC_STOP);
   end
endmodule

// File: rtl/seq16_alu.sv
module seq16_alu #(
   parameter int WORD_W = 16
) (
   input  logic              sel_and,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] y
);
   always_comb y = sel_and ? (a & b) : (a + b);
endmodule

// File: rtl/seq16_regfile.sv
module seq16_regfile #(
   parameter int WORD_W = 16,
   parameter int NREG   = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [WORD_W-1:0]       wdata,
   input  logic [$clog2(NREG)-1:0] ra0,
   input  logic [$clog2(NREG)-1:0] ra1,
   input  logic [$clog2(NREG)-1:0] ra2,
   output logic [WORD_W-1:0]       rd0,
   output logic [WORD_W-1:0]       rd1,
   output logic [WORD_W-1:0]       rd2
);
   logic [WORD_W-1:0] cells [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_cell
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (we && (waddr == i[$clog2(NREG)-1:0]))
            q <= wdata;
      end
      assign cells[i] = q;
   end

   assign rd0 = cells[ra0];
   assign rd1 = cells[ra1];
   assign rd2 = cells[ra2];
endmodule

// File: rtl/seq16_core.sv
module seq16_core
   import seq16_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NREG   = 8
) (
   input  logic              clk,
   input  logic              rst,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              halted,
   output logic [3:0]        dbg_phase,
   output logic [WORD_W-1:0] dbg_pc,
   output logic [WORD_W-1:0] dbg_ir
);
   localparam int RA_W = $clog2(NREG);
   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   if (WORD_W != 16) begin : g_bad_width
      $error("seq16_core: the instruction encoding needs WORD_W == 16");
   end
   if (NREG != 8) begin : g_bad_nreg
      $error("seq16_core: 3-bit register fields need NREG == 8");
   end

   phase_t            phase_q;
   logic [WORD_W-1:0] pc_q, ir_q, mar_q, mdr_q, opa_q, opb_q, res_q;

   logic [2:0]        f_dst, f_src1, f_src2;
   logic              imm_mode, is_alu, is_and, is_ld, is_st, is_jmp, is_halt;
   logic [WORD_W-1:0] imm_val, off_val;
   logic [WORD_W-1:0] rd0, rd1, rd2, alu_y, wb_data;
   logic              wb_en;

   seq16_decode #(.WORD_W(WORD_W)) u_dec (
      .ir(ir_q), .f_dst(f_dst), .f_src1(f_src1), .f_src2(f_src2),
      .imm_mode(imm_mode), .imm_val(imm_val), .off_val(off_val),
      .is_alu(is_alu), .is_and(is_and), .is_ld(is_ld), .is_st(is_st),
      .is_jmp(is_jmp), .is_halt(is_halt)
   );

   seq16_alu #(.WORD_W(WORD_W)) u_alu (
      .sel_and(is_and), .a(opa_q), .b(opb_q), .y(alu_y)
   );

   assign wb_en   = (phase_q == PH_STORE) && (is_alu || is_ld);
   assign wb_data = is_ld ? mdr_q : res_q;

   seq16_regfile #(.WORD_W(WORD_W), .NREG(NREG)) u_rf (
      .clk(clk), .rst(rst), .we(wb_en), .waddr(RA_W'(f_dst)), .wdata(wb_data),
      .ra0(RA_W'(f_src1)), .ra1(RA_W'(f_src2)), .ra2(RA_W'(f_dst)),
      .rd0(rd0), .rd1(rd1), .rd2(rd2)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_FETCH;
         pc_q    <= '0;
         ir_q    <= '0;
         mar_q   <= '0;
         mdr_q   <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         res_q   <= '0;
      end else begin
         case (phase_q)
            PH_FETCH: begin
               mar_q   <= pc_q;
               pc_q    <= pc_q + ONE;
               phase_q <= PH_FREAD;
            end
            PH_FREAD: phase_q <= PH_FLOAD;
            PH_FLOAD: begin
               mdr_q   <= mem_rdata;
               ir_q    <= mem_rdata;
               phase_q <= PH_DECODE;
            end
            PH_DECODE: begin
               if (is_halt)
                  phase_q <= PH_HALT;
               else if (is_alu || is_ld || is_st || is_jmp)
                  phase_q <= PH_EVAL;
               else
                  phase_q <= PH_FETCH;
            end
            PH_EVAL: begin
               if (is_ld || is_st)
                  mar_q <= rd0 + off_val;
               phase_q <= PH_OPS;
            end
            PH_OPS: begin
               opa_q <= rd0;
               opb_q <= imm_mode ? imm_val : rd1;
               if (is_st)
                  mdr_q <= rd2;
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               res_q <= alu_y;
               if (is_ld)
                  mdr_q <= mem_rdata;
               if (is_jmp)
                  pc_q <= rd0;
               phase_q <= PH_STORE;
            end
            PH_STORE: phase_q <= PH_FETCH;
            PH_HALT:  phase_q <= PH_HALT;
            default:  phase_q <= PH_FETCH;
         endcase
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign mem_rd    = (phase_q == PH_FREAD) || ((phase_q == PH_OPS) && is_ld);
   assign mem_wr    = (phase_q == PH_STORE) && is_st;
   assign halted    = (phase_q == PH_HALT);
   assign dbg_phase = phase_q;
   assign dbg_pc    = pc_q;
   assign dbg_ir    = ir_q;
endmodule

// File: rtl/seq16_core_chk.sv
module seq16_core_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] mem_addr,
   input logic         mem_rd,
   input logic         mem_wr,
   input logic         halted,
   input logic [3:0]   dbg_phase,
   input logic [W-1:0] dbg_pc
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   // R12
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R2
   fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_phase == 4'd0) |=> (mem_rd && (mem_addr == $past(dbg_pc))));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_phase == 4'd0) |=> (dbg_pc == $past(dbg_pc) + ONE));

   // R9
   phase_seq_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_phase inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6})
      |=> (dbg_phase == $past(dbg_phase) + 4'd1));

   // R9
   store_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_phase == 4'd7) |=> (dbg_phase == 4'd0));

   // R11
   decode_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_phase == 4'd3) |=> (dbg_phase inside {4'd0, 4'd4, 4'd8}));

   // R10
   halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(dbg_pc) && !mem_rd && !mem_wr));

   // R7
   write_phase_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (dbg_phase == 4'd7));
endmodule

bind seq16_core seq16_core_chk #(.W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .halted(halted), .dbg_phase(dbg_phase), .dbg_pc(dbg_pc)
);

// File: tb/seq16_core_test.sv
module seq16_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, halted;
   logic [3:0]  dbg_phase;
   logic [15:0] dbg_pc, dbg_ir;

   int total = 0;
   int fails = 0;

   logic [15:0] mem [0:255];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_a  = '0;
   logic [15:0] ld_d  = '0;
   int          wr_count, both_count, halt_strobes;

   localparam logic [15:0] FILL = 16'hDEAD;
   localparam logic [15:0] HLT  = 16'hF000;

   always #10 clk = ~clk;

   seq16_core uut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .halted(halted), .dbg_phase(dbg_phase), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir)
   );

   always @(posedge clk) begin
      if (ld_en) mem[ld_a] <= ld_d;
      else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(posedge clk) begin
      if (rst) begin
         wr_count <= 0; both_count <= 0; halt_strobes <= 0;
      end else begin
         if (mem_wr) wr_count <= wr_count + 1;
         if (mem_rd && mem_wr) both_count <= both_count + 1;
         if (halted && (mem_rd || mem_wr)) halt_strobes <= halt_strobes + 1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   function automatic logic [15:0] e_rr(input logic [3:0] op, input logic [2:0] d, s1, s2);
      return {op, d, s1, 3'b000, s2};
   endfunction
   function automatic logic [15:0] e_ri(input logic [3:0] op, input logic [2:0] d, s1, input logic [4:0] im);
      return {op, d, s1, 1'b1, im};
   endfunction
   function automatic logic [15:0] e_m(input logic [3:0] op, input logic [2:0] d, b, input logic [5:0] off);
      return {op, d, b, off};
   endfunction
   function automatic logic [15:0] e_j(input logic [2:0] b);
      return {4'b1100, 3'b000, b, 6'b000000};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [15:0] d);
      ld_en = 1'b1; ld_a = a; ld_d = d;
      @(negedge clk);
   endtask

   task automatic prep();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 256; i++) poke(i[7:0], FILL);
   endtask

   task automatic go();
      ld_en = 1'b0;
      rst = 1'b0;
   endtask

   task automatic run_to_halt(output int n);
      n = 0;
      while (!halted && n < 2000) begin
         @(negedge clk);
         n++;
      end
      if (!halted) check("R10 run ended by halt", 16'h0, 16'h1);
   endtask

   task automatic t_add();
      int n;
      prep();
      poke(0, e_ri(4'b0001, 3'd1, 3'd0, 5'd7));
      poke(1, e_ri(4'b0001, 3'd2, 3'd0, 5'b11101));
      poke(2, e_rr(4'b0001, 3'd3, 3'd1, 3'd2));
      poke(3, e_ri(4'b0001, 3'd4, 3'd3, 5'd15));
      poke(4, e_m(4'b0111, 3'd1, 3'd0, 6'd20));
      poke(5, e_m(4'b0111, 3'd2, 3'd0, 6'd21));
      poke(6, e_m(4'b0111, 3'd3, 3'd0, 6'd22));
      poke(7, e_m(4'b0111, 3'd4, 3'd0, 6'd23));
      poke(8, HLT);
      go();
      run_to_halt(n);
      check("R4 add positive immediate", mem[20], 16'h0007);
      check("R4 add negative immediate", mem[21], 16'hFFFD);
      check("R3 add register form", mem[22], 16'h0004);
      check("R3 add chain", mem[23], 16'h0013);
   endtask

   task automatic t_reset();
      int n;
      prep();
      check("R1 reset pc", dbg_pc, 16'h0000);
      check("R1 reset phase", {12'h0, dbg_phase}, 16'h0000);
      check("R1 reset halted", {15'h0, halted}, 16'h0000);
      check("R1 reset strobes", {14'h0, mem_rd, mem_wr}, 16'h0000);
      for (int i = 0; i < 8; i++) poke(i[7:0], e_m(4'b0111, i[2:0], 3'd0, 6'(20 + i)));
      poke(8, HLT);
      go();
      run_to_halt(n);
      for (int i = 0; i < 8; i++) check("R1 register cleared", mem[20 + i], 16'h0000);
   endtask

   task automatic t_fetch();
      logic [15:0] w;
      prep();
      w = e_ri(4'b0001, 3'd1, 3'd0, 5'd3);
      poke(0, w);
      poke(1, HLT);
      go();
      for (int n = 0; n <= 8; n++) begin
         check("R9 phase order", {12'h0, dbg_phase}, (n == 8) ? 16'h0 : 16'(n));
         if (n == 1) begin
            check("R2 fetch read strobe", {15'h0, mem_rd}, 16'h0001);
            check("R2 fetch address", mem_addr, 16'h0000);
            check("R2 pc advanced", dbg_pc, 16'h0001);
         end
         if (n == 3) check("R2 ir loaded", dbg_ir, w);
         @(negedge clk);
      end
   endtask

   task automatic t_and();
      int n;
      prep();
      poke(30, 16'hF0F0);
      poke(31, 16'h3C3C);
      poke(0, e_m(4'b0110, 3'd1, 3'd0, 6'd30));
      poke(1, e_m(4'b0110, 3'd2, 3'd0, 6'd31));
      poke(2, e_rr(4'b0101, 3'd3, 3'd1, 3'd2));
      poke(3, e_ri(4'b0101, 3'd4, 3'd1, 5'b10000));
      poke(4, e_ri(4'b0101, 3'd5, 3'd2, 5'd5));
      poke(5, e_m(4'b0111, 3'd3, 3'd0, 6'd20));
      poke(6, e_m(4'b0111, 3'd4, 3'd0, 6'd21));
      poke(7, e_m(4'b0111, 3'd5, 3'd0, 6'd22));
      poke(8, HLT);
      go();
      run_to_halt(n);
      check("R5 and register form", mem[20], 16'h3030);
      check("R4 and immediate -16", mem[21], 16'hF0F0);
      check("R5 and immediate 5", mem[22], 16'h0004);
   endtask

   task automatic t_mem();
      int n;
      prep();
      poke(58, 16'hBEEF);
      poke(0, e_ri(4'b0001, 3'd6, 3'd0, 5'd15));
      poke(1, e_rr(4'b0001, 3'd6, 3'd6, 3'd6));
      poke(2, e_rr(4'b0001, 3'd6, 3'd6, 3'd6));
      poke(3, e_m(4'b0110, 3'd1, 3'd6, 6'b111110));
      poke(4, e_m(4'b0111, 3'd1, 3'd6, 6'b111111));
      poke(5, e_m(4'b0111, 3'd1, 3'd6, 6'd3));
      poke(6, HLT);
      go();
      run_to_halt(n);
      check("R6 load negative offset", mem[59], 16'hBEEF);
      check("R7 store positive offset", mem[63], 16'hBEEF);
      check("R7 untouched word", mem[60], FILL);
      check("R7 write count", 16'(wr_count), 16'd2);
      check("R12 strobes exclusive", 16'(both_count), 16'd0);
   endtask

   task automatic t_jmp();
      int n;
      prep();
      poke(0, e_ri(4'b0001, 3'd2, 3'd0, 5'd12));
      poke(1, e_j(3'd2));
      poke(2, e_ri(4'b0001, 3'd3, 3'd0, 5'd1));
      poke(3, e_m(4'b0111, 3'd3, 3'd0, 6'd20));
      poke(4, HLT);
      poke(12, e_ri(4'b0001, 3'd4, 3'd0, 5'd9));
      poke(13, e_m(4'b0111, 3'd4, 3'd0, 6'd21));
      poke(14, e_m(4'b0111, 3'd2, 3'd0, 6'd22));
      poke(15, HLT);
      go();
      run_to_halt(n);
      check("R8 skipped code", mem[20], FILL);
      check("R8 target code ran", mem[21], 16'h0009);
      check("R8 jump register unchanged", mem[22], 16'h000C);
      check("R8 final pc", dbg_pc, 16'h0010);
   endtask

   task automatic t_unknown();
      int n;
      prep();
      poke(0, e_ri(4'b0001, 3'd1, 3'd0, 5'd5));
      poke(1, 16'h3245);
      poke(2, 16'h9FFF);
      poke(3, e_m(4'b0111, 3'd1, 3'd0, 6'd20));
      poke(4, HLT);
      go();
      run_to_halt(n);
      check("R9 R11 cycles to halt", 16'(n), 16'd28);
      check("R11 destination unchanged", mem[20], 16'h0005);
      check("R11 no extra writes", 16'(wr_count), 16'd1);
      check("R11 final pc", dbg_pc, 16'h0005);
   endtask

   task automatic t_halt();
      int n;
      prep();
      poke(0, HLT);
      poke(1, e_ri(4'b0001, 3'd1, 3'd0, 5'd1));
      go();
      run_to_halt(n);
      check("R10 halt latency", 16'(n), 16'd4);
      repeat (20) @(negedge clk);
      check("R10 halted sticky", {15'h0, halted}, 16'h0001);
      check("R10 halt phase", {12'h0, dbg_phase}, 16'h0008);
      check("R10 pc frozen", dbg_pc, 16'h0001);
      check("R10 no strobes", 16'(halt_strobes), 16'd0);
   endtask

   initial begin
      t_add();
      t_reset();
      t_fetch();
      t_and();
      t_mem();
      t_jmp();
      t_unknown();
      t_halt();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule